// File: doc/BRIEF.md
# Packet Receive Bus Driver with Throttled Read Handshake

This block sits on the device side of a packet receive interface. It drains per-port receive queues and presents their contents to a link-layer device. The link layer paces the transfer with an active-low read enable. Each cycle in which the enable is sampled low allows at most one queue read. The outputs then change on the next rising clock edge. A cycle with the enable high leaves every output exactly as it was.

A configuration input selects the bus shape while the block is idle or held in reset:
- **Wide mode:** one 32-bit bus is shared by all ports. Before it sends words from a port other than the one last addressed, the block inserts one address cycle. On that cycle the start-of-transfer flag is high and the port number is on the low data bits. Ports are served round-robin, and a port change is made only at packet boundaries.
- **Lane mode:** the bus splits into four independent 8-bit lanes. Each lane has its own enable, its own flags and its own parity bit.

Parity is odd unless a second configuration input selects even parity.

Top module: `rxd_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, every valid bit and the start-of-transfer flag are low.
- R2: A read enable sampled high performs no queue pop, and every output it governs keeps its value on the next edge. In wide mode enable bit 0 governs the whole bus. In lane mode bit l governs lane l.
- R3: A read enable sampled low while data is available pops exactly one word, and valid is high on the next edge. The queue word layout is, from the most significant bit down: start bit 36, end bit 35, error bit 34, modulo in bits 33:32, data in bits 31:0. In wide mode the word's data, start, end and error bits appear on the bus. In lane mode lane l carries data bits 7:0 of port l's word on rx_dat[8l+7:8l].
- R4: A read enable sampled low with nothing to send makes valid low and pops nothing. Output resumes on the first cycle after data becomes available.
- R5: Parity is odd by default: the count of ones in the covered data plus the parity bit is odd. When cfg_even is 1, that count is even. In wide mode rx_par[0] covers all 32 bits. In lane mode rx_par[l] covers lane l. Parity is correct on every cycle with valid or start-of-transfer high.
- R6: In wide mode, before the first word from a port that differs from the last addressed port (or from any port after reset), the block drives exactly one cycle with rx_sx high, valid low, the port number on rx_dat and all other bits zero. No pop happens on that cycle.
- R7: In wide mode the port changes only after an end-of-packet word. The next port is the first non-empty one in increasing order, wrapping around, starting after the last addressed port. After reset the last addressed port counts as port 0. At most one queue is popped per cycle.
- R8: In wide mode rx_mod carries the word's modulo field (the number of unused trailing bytes, 0 meaning all four bytes are valid) on end-of-packet words, and 0 on all other words. In lane mode rx_mod and rx_sx stay 0.
- R9: In lane mode each lane follows only its own enable and its own queue. A stalled or empty lane does not disturb the others.
- R10: Under any throttling pattern, every queued word is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all outputs launch on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = shared 32-bit bus, 0 = four 8-bit lanes |
| cfg_even | input | 1 | 1 = even parity, 0 = odd parity |
| q_empty | input | 4 | Per-port queue empty flags |
| q_pop | output | 4 | Per-port queue pop strobes |
| q_word | input | 148 | Head word of each queue, 37 bits per port, port p at [37p+36:37p] |
| rd_en_n | input | 4 | Active-low read enables (bit 0 only in wide mode) |
| rx_dat | output | 32 | Data bus or four lanes |
| rx_par | output | 4 | Parity (bit 0 in wide mode, one per lane otherwise) |
| rx_mod | output | 2 | Count of unused trailing bytes on the last word |
| rx_sop | output | 4 | Start-of-packet flags |
| rx_eop | output | 4 | End-of-packet flags |
| rx_err | output | 4 | Packet error flags |
| rx_sx | output | 1 | Port address cycle marker (wide mode) |
| rx_val | output | 4 | Valid flags qualifying the other outputs |

## Verification
The hold rule and the port address insertion can fall in the same cycle. An enable sampled high may land exactly where an address cycle, or the last word of a packet, was about to go out. The bench provokes this by driving pseudo-random throttle patterns against queues that hold packets of varied lengths on several ports. It checks that the held cycle repeats the previous outputs bit for bit. It also checks that the address cycle then appears exactly once, for the port that round-robin order predicts, before that port's next word.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int NPORT  = 4;
  localparam int BUS_W  = 32;
  localparam int LANE_W = BUS_W / NPORT;
  localparam int PORT_W = $clog2(NPORT);
  localparam int MOD_W  = $clog2(BUS_W / 8);

  typedef struct packed {
    logic             sop;
    logic             eop;
    logic             err;
    logic [MOD_W-1:0] mod;
    logic [BUS_W-1:0] dat;
  } qword_t;

  localparam int QW = $bits(qword_t);

  // reduction XOR of the covered bits -> parity bit for the chosen polarity
  function automatic logic par_of(input logic red, input logic even);
    return even ? red : ~red;
  endfunction
endpackage

// File: rtl/rxd_rr_pick.sv
module rxd_rr_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    int c;
    found = 1'b0;
    idx   = last;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last) + k) % N;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/rxd_lane.sv
module rxd_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         act,
  input  logic         even,
  input  logic         en_n,
  input  logic         empty,
  input  logic [W-1:0] din,
  input  logic         sop_i,
  input  logic         eop_i,
  input  logic         err_i,
  output logic         pop,
  output logic [W-1:0] dat,
  output logic         par,
  output logic         sop,
  output logic         eop,
  output logic         err,
  output logic         val
);
  import rxd_pkg::*;

  logic take;
  assign take = act & ~en_n;
  assign pop  = take & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat <= '0;
      par <= 1'b0;
      sop <= 1'b0;
      eop <= 1'b0;
      err <= 1'b0;
      val <= 1'b0;
    end else if (take) begin
      if (!empty) begin
        dat <= din;
        par <= par_of(^din, even);
        sop <= sop_i;
        eop <= eop_i;
        err <= err_i;
        val <= 1'b1;
      end else begin
        sop <= 1'b0;
        eop <= 1'b0;
        err <= 1'b0;
        val <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxd_wide.sv
module rxd_wide #(
  parameter int NP = rxd_pkg::NPORT,
  parameter int PW = $clog2(NP)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            act,
  input  logic                            even,
  input  logic                            en_n,
  input  logic [NP-1:0]                   empty,
  input  rxd_pkg::qword_t [NP-1:0]        words,
  output logic [NP-1:0]                   pop,
  output logic [rxd_pkg::BUS_W-1:0]       dat,
  output logic                            par,
  output logic [rxd_pkg::MOD_W-1:0]       mod,
  output logic                            sop,
  output logic                            eop,
  output logic                            err,
  output logic                            sx,
  output logic                            val
);
  import rxd_pkg::*;

  logic [PW-1:0] cur;
  logic          addr_ok;
  logic          in_pkt;

  logic          found;
  logic [PW-1:0] pk_idx;
  logic          take;
  logic          go_word;
  logic          go_sx;
  qword_t        w;
  logic [BUS_W-1:0] addr_bus;

  rxd_rr_pick #(.N(NP), .IW(PW)) i_pick (
    .req   (~empty),
    .last  (cur),
    .found (found),
    .idx   (pk_idx)
  );

  assign take     = act & ~en_n;
  assign w        = words[cur];
  assign addr_bus = BUS_W'(pk_idx);

  always_comb begin
    go_word = 1'b0;
    go_sx   = 1'b0;
    if (take) begin
      if (in_pkt) begin
        go_word = ~empty[cur];
      end else if (found) begin
        if (addr_ok && pk_idx == cur) go_word = 1'b1;
        else                          go_sx   = 1'b1;
      end
    end
    pop = '0;
    pop[cur] = go_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= '0;
      addr_ok <= 1'b0;
      in_pkt  <= 1'b0;
      dat     <= '0;
      par     <= 1'b0;
      mod     <= '0;
      sop     <= 1'b0;
      eop     <= 1'b0;
      err     <= 1'b0;
      sx      <= 1'b0;
      val     <= 1'b0;
    end else if (take) begin
      if (go_word) begin
        dat    <= w.dat;
        par    <= par_of(^w.dat, even);
        mod    <= w.eop ? w.mod : '0;
        sop    <= w.sop;
        eop    <= w.eop;
        err    <= w.err;
        sx     <= 1'b0;
        val    <= 1'b1;
        in_pkt <= ~w.eop;
      end else if (go_sx) begin
        dat     <= addr_bus;
        par     <= par_of(^addr_bus, even);
        mod     <= '0;
        sop     <= 1'b0;
        eop     <= 1'b0;
        err     <= 1'b0;
        sx      <= 1'b1;
        val     <= 1'b0;
        cur     <= pk_idx;
        addr_ok <= 1'b1;
        in_pkt  <= 1'b1;
      end else begin
        mod <= '0;
        sop <= 1'b0;
        eop <= 1'b0;
        err <= 1'b0;
        sx  <= 1'b0;
        val <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxd_top.sv
module rxd_top
  import rxd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wide,
  input  logic                  cfg_even,
  input  logic [NPORT-1:0]      q_empty,
  output logic [NPORT-1:0]      q_pop,
  input  logic [NPORT*QW-1:0]   q_word,
  input  logic [NPORT-1:0]      rd_en_n,
  output logic [BUS_W-1:0]      rx_dat,
  output logic [NPORT-1:0]      rx_par,
  output logic [MOD_W-1:0]      rx_mod,
  output logic [NPORT-1:0]      rx_sop,
  output logic [NPORT-1:0]      rx_eop,
  output logic [NPORT-1:0]      rx_err,
  output logic                  rx_sx,
  output logic [NPORT-1:0]      rx_val
);
  qword_t [NPORT-1:0] words;

  logic [NPORT-1:0]  w_pop;
  logic [BUS_W-1:0]  w_dat;
  logic              w_par;
  logic [MOD_W-1:0]  w_mod;
  logic              w_sop, w_eop, w_err, w_sx, w_val;

  logic [NPORT-1:0]  l_pop;
  logic [BUS_W-1:0]  l_dat;
  logic [NPORT-1:0]  l_par, l_sop, l_eop, l_err, l_val;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign words[p] = q_word[p*QW +: QW];

    rxd_lane #(.W(LANE_W)) i_lane (
      .clk   (clk),
      .rst   (rst),
      .act   (~cfg_wide),
      .even  (cfg_even),
      .en_n  (rd_en_n[p]),
      .empty (q_empty[p]),
      .din   (words[p].dat[LANE_W-1:0]),
      .sop_i (words[p].sop),
      .eop_i (words[p].eop),
      .err_i (words[p].err),
      .pop   (l_pop[p]),
      .dat   (l_dat[p*LANE_W +: LANE_W]),
      .par   (l_par[p]),
      .sop   (l_sop[p]),
      .eop   (l_eop[p]),
      .err   (l_err[p]),
      .val   (l_val[p])
    );
  end

  rxd_wide #(.NP(NPORT)) i_wide (
    .clk   (clk),
    .rst   (rst),
    .act   (cfg_wide),
    .even  (cfg_even),
    .en_n  (rd_en_n[0]),
    .empty (q_empty),
    .words (words),
    .pop   (w_pop),
    .dat   (w_dat),
    .par   (w_par),
    .mod   (w_mod),
    .sop   (w_sop),
    .eop   (w_eop),
    .err   (w_err),
    .sx    (w_sx),
    .val   (w_val)
  );

  localparam logic [NPORT-2:0] ZHI = '0;

  assign q_pop  = cfg_wide ? w_pop : l_pop;
  assign rx_dat = cfg_wide ? w_dat : l_dat;
  assign rx_par = cfg_wide ? {ZHI, w_par} : l_par;
  assign rx_mod = cfg_wide ? w_mod : '0;
  assign rx_sop = cfg_wide ? {ZHI, w_sop} : l_sop;
  assign rx_eop = cfg_wide ? {ZHI, w_eop} : l_eop;
  assign rx_err = cfg_wide ? {ZHI, w_err} : l_err;
  assign rx_sx  = cfg_wide & w_sx;
  assign rx_val = cfg_wide ? {ZHI, w_val} : l_val;
endmodule

// File: rtl/rxd_chk.sv
module rxd_chk
  import rxd_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cfg_wide,
  input logic                cfg_even,
  input logic [NPORT-1:0]    q_empty,
  input logic [NPORT-1:0]    q_pop,
  input logic [NPORT-1:0]    rd_en_n,
  input logic [BUS_W-1:0]    rx_dat,
  input logic [NPORT-1:0]    rx_par,
  input logic [MOD_W-1:0]    rx_mod,
  input logic [NPORT-1:0]    rx_sop,
  input logic [NPORT-1:0]    rx_eop,
  input logic [NPORT-1:0]    rx_err,
  input logic                rx_sx,
  input logic [NPORT-1:0]    rx_val
);
  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_wide && rd_en_n[0] |=> $stable(rx_dat) && $stable(rx_val) && $stable(rx_sx) && $stable(rx_par) && $stable(rx_mod) && $stable(rx_eop)); // R2

  AST_NO_POP_HELD: assert property (@(posedge clk) disable iff (rst)
    cfg_wide && rd_en_n[0] |-> q_pop == '0); // R2

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (q_pop & q_empty) == '0); // R4

  AST_SX_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_sx |-> !rx_val[0]); // R6

  AST_PAR_WIDE: assert property (@(posedge clk) disable iff (rst)
    cfg_wide && (rx_val[0] || rx_sx) |-> rx_par[0] == ((^rx_dat) ^ !cfg_even)); // R5

  AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
    cfg_wide |-> $onehot0(q_pop)); // R7

  AST_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cfg_wide |-> rx_mod == '0 && !rx_sx); // R8

  for (genvar l = 0; l < NPORT; l++) begin : g_lane
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !cfg_wide && rd_en_n[l] |=> $stable(rx_dat[l*LANE_W +: LANE_W]) && $stable(rx_val[l]) && $stable(rx_par[l])); // R9
  end
endmodule

bind rxd_top rxd_chk i_chk (.*);

// File: tb/test_rxd_top.sv
`timescale 1ns/1ps
module test_rxd_top;
  import rxd_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wide = 1'b1;
  logic cfg_even = 1'b0;
  logic [NPORT-1:0] q_empty, q_pop, rd_en_n;
  logic [NPORT*QW-1:0] q_word;
  logic [BUS_W-1:0] rx_dat;
  logic [NPORT-1:0] rx_par, rx_sop, rx_eop, rx_err, rx_val;
  logic [MOD_W-1:0] rx_mod;
  logic rx_sx;

  always #4 clk = ~clk;

  rxd_top i_rxd_top (.*);

  qword_t mem [NPORT][64];
  int tail [NPORT];
  int head [NPORT];
  int got  [NPORT];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_cur; bit m_addr_ok, m_inpkt;
  logic [NPORT-1:0] pen;
  logic [15:0] lfsr = 16'hACE1;
  logic [BUS_W-1:0] s_dat; logic [NPORT-1:0] s_par, s_sop, s_eop, s_err, s_val;
  logic [MOD_W-1:0] s_mod; logic s_sx;

  for (genvar p = 0; p < NPORT; p++) begin : g_q
    assign q_empty[p] = (head[p] == tail[p]);
    assign q_word[p*QW +: QW] = mem[p][head[p] % 64];
  end

  always @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (rst) head[p] <= 0;
      else if (q_pop[p]) head[p] <= head[p] + 1;
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic qword_t mk(int p, int i, bit s, bit e, bit r);
    qword_t w;
    w.dat = (32'(p*64 + i + 1) * 32'h9E3779B1) ^ (32'(p) << 28);
    w.mod = MOD_W'(i + p);
    w.sop = s; w.eop = e; w.err = r;
    return w;
  endfunction

  task automatic push(int p, bit s, bit e);
    mem[p][tail[p] % 64] = mk(p, tail[p], s, e, (tail[p] % 5) == 3);
    tail[p]++;
  endtask

  task automatic load(int p, int npkt, int base);
    for (int k = 0; k < npkt; k++) begin
      int len = 1 + ((base + k) % 4);
      for (int j = 0; j < len; j++) push(p, j == 0, j == len - 1);
    end
  endtask

  function automatic int remain();
    int r = 0;
    for (int p = 0; p < NPORT; p++) r += tail[p] - got[p];
    return r;
  endfunction

  function automatic int rr_exp();
    for (int k = 1; k <= NPORT; k++) begin
      int c = (m_cur + k) % NPORT;
      if (tail[c] > got[c]) return c;
    end
    return -1;
  endfunction

  function automatic logic [63:0] outs();
    return {9'd0, rx_dat, rx_par, rx_mod, rx_sop, rx_eop, rx_err, rx_sx, rx_val};
  endfunction
  function automatic logic [63:0] snap();
    return {9'd0, s_dat, s_par, s_mod, s_sop, s_eop, s_err, s_sx, s_val};
  endfunction

  task automatic check_wide();
    if (pen[0]) begin
      chk(outs() == snap(), "R2 hold", outs(), snap());
    end else if (rx_sx) begin
      chk(!m_inpkt, "R7 switch only after eop", 64'(m_inpkt), 0);
      chk(int'(rx_dat) == rr_exp(), "R7 round robin", 64'(rx_dat), 64'(rr_exp()));
      chk(!m_addr_ok || int'(rx_dat) != m_cur, "R6 address only on change", 64'(rx_dat), 64'(m_cur));
      m_cur = int'(rx_dat[PORT_W-1:0]); m_addr_ok = 1; m_inpkt = 1;
    end else if (rx_val[0]) begin
      qword_t e = mem[m_cur][got[m_cur] % 64];
      if (!m_inpkt) chk(m_addr_ok && rr_exp() == m_cur, "R6 direct word needs address", 64'(rr_exp()), 64'(m_cur));
      chk(rx_dat == e.dat && rx_sop[0] == e.sop && rx_eop[0] == e.eop && rx_err[0] == e.err,
          "R3 R10 wide word", {rx_sop[0], rx_eop[0], rx_err[0], rx_dat}, {e.sop, e.eop, e.err, e.dat});
      chk(rx_mod == (e.eop ? e.mod : 2'd0), "R8 modulo", 64'(rx_mod), 64'(e.eop ? e.mod : 2'd0));
      got[m_cur]++;
      m_inpkt = !e.eop;
    end else begin
      chk(remain() == 0, "R4 idle only when empty", 64'(remain()), 0);
    end
    if (!pen[0] && (rx_val[0] || rx_sx))
      chk(rx_par[0] == ((^rx_dat) ^ !cfg_even), "R5 wide parity", 64'(rx_par[0]), 64'((^rx_dat) ^ !cfg_even));
  endtask

  task automatic check_narrow();
    chk(rx_mod == 0 && rx_sx == 0, "R8 lane mode quiet", {rx_sx, rx_mod}, 0);
    for (int l = 0; l < NPORT; l++) begin
      logic [12:0] a = {rx_dat[l*8 +: 8], rx_par[l], rx_sop[l], rx_eop[l], rx_err[l], rx_val[l]};
      logic [12:0] b = {s_dat[l*8 +: 8], s_par[l], s_sop[l], s_eop[l], s_err[l], s_val[l]};
      if (pen[l]) begin
        chk(a == b, "R2 R9 lane hold", 64'(a), 64'(b));
      end else if (rx_val[l]) begin
        qword_t e = mem[l][got[l] % 64];
        chk(rx_dat[l*8 +: 8] == e.dat[7:0] && rx_sop[l] == e.sop && rx_eop[l] == e.eop && rx_err[l] == e.err,
            "R3 R9 R10 lane word", 64'(a), {e.dat[7:0], 1'b0, e.sop, e.eop, e.err, 1'b1});
        chk(rx_par[l] == ((^rx_dat[l*8 +: 8]) ^ !cfg_even), "R5 lane parity", 64'(rx_par[l]), 64'((^rx_dat[l*8 +: 8]) ^ !cfg_even));
        got[l]++;
      end else begin
        chk(tail[l] == got[l], "R4 lane idle only when empty", 64'(tail[l] - got[l]), 0);
      end
    end
  endtask

  task automatic tick(input logic [NPORT-1:0] en);
    rd_en_n = en; pen = en;
    s_dat = rx_dat; s_par = rx_par; s_mod = rx_mod; s_sop = rx_sop;
    s_eop = rx_eop; s_err = rx_err; s_sx = rx_sx; s_val = rx_val;
    @(posedge clk);
    @(negedge clk);
    if (cfg_wide) check_wide(); else check_narrow();
  endtask

  function automatic logic [15:0] step_lfsr(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic do_reset(bit wide, bit even);
    rst = 1'b1; rd_en_n = '1;
    cfg_wide = wide; cfg_even = even;
    for (int p = 0; p < NPORT; p++) begin tail[p] = 0; got[p] = 0; end
    m_cur = 0; m_addr_ok = 0; m_inpkt = 0;
    repeat (3) @(negedge clk);
    chk(rx_val == 0 && rx_sx == 0, "R1 reset outputs", {rx_sx, rx_val}, 0);
    rst = 1'b0;
    tick('1);
    chk(rx_val == 0 && rx_sx == 0 && q_pop == 0, "R1 after reset", {q_pop, rx_sx, rx_val}, 0);
  endtask

  task automatic verify_drained(string tag);
    for (int p = 0; p < NPORT; p++)
      chk(got[p] == tail[p], tag, 64'(got[p]), 64'(tail[p]));
  endtask

  initial begin
    rd_en_n = '1;
    for (int p = 0; p < NPORT; p++) begin head[p] = 0; tail[p] = 0; got[p] = 0; end

    // wide mode, odd parity, throttled, port 1 empty
    do_reset(1'b1, 1'b0);
    load(0, 3, 0); load(2, 4, 1); load(3, 2, 3);
    for (int i = 0; i < 3000 && (remain() != 0 || m_inpkt); i++) begin
      lfsr = step_lfsr(lfsr);
      tick({3'b111, lfsr[0] & lfsr[3]});
    end
    verify_drained("R10 wide throttled drain");
    repeat (3) tick('0);
    chk(rx_val[0] == 0, "R4 idle with enable low", 64'(rx_val), 0);
    push(m_cur, 1'b1, 1'b1);
    tick('0);
    chk(rx_val[0] == 1 && rx_sx == 0, "R4 resume on same port", {rx_sx, rx_val}, 1);
    push((m_cur + 1) % NPORT, 1'b1, 1'b1);
    tick('0);
    chk(rx_sx == 1, "R6 address before new port", 64'(rx_sx), 1);
    tick('0);
    chk(rx_val[0] == 1, "R6 word after address", 64'(rx_val), 1);
    repeat (2) tick('0);
    verify_drained("R10 wide resume drain");

    // wide mode, even parity, no throttle, all ports
    do_reset(1'b1, 1'b1);
    for (int p = 0; p < NPORT; p++) load(p, 4, p);
    for (int i = 0; i < 3000 && (remain() != 0 || m_inpkt); i++) tick('0);
    verify_drained("R10 wide back-to-back drain");

    // wide mode, odd parity, heavy throttle
    do_reset(1'b1, 1'b0);
    load(1, 5, 2); load(3, 5, 0);
    for (int i = 0; i < 4000 && (remain() != 0 || m_inpkt); i++) begin
      lfsr = step_lfsr(lfsr);
      tick({3'b111, lfsr[1] | lfsr[5]});
    end
    verify_drained("R10 wide heavy throttle drain");

    // lane mode, even then odd parity, independent throttles, lane 3 empty
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(1'b0, pass == 0);
      load(0, 4, 0); load(1, 3, 1); load(2, 5, 2);
      for (int i = 0; i < 3000 && remain() != 0; i++) begin
        lfsr = step_lfsr(lfsr);
        tick({lfsr[7], lfsr[2] & lfsr[4], (i < 40) ? 1'b1 : lfsr[9], lfsr[0]});
      end
      verify_drained("R9 R10 lane drain");
    end

    summary();
    $finish;
  end
endmodule